// File: doc/BRIEF.md
# Two-Slot Card Presence and Status Reporter

This block watches the card-detect switches of two card slots and turns them into two active-low status lines for a host. Insertion is qualified by a debounce window: the switch must read "card present" without interruption for a set number of clock cycles before the slot counts as occupied. Removal is taken on the first low sample, with no filtering. If a slot loses its card while that slot's session is open, the block sends a one-cycle removal request to the session sequencer so that it can shut the card down at once.

A slot-select input chooses which slot the primary status line describes. On that line a high level means the selected slot holds a card and has no latched session fault. A low level means the slot is empty or has a fault. The secondary status line always shows the debounced presence of the slot that is not selected. A fault seen while a slot is in session is latched. The latch stays until the sequencer reports that the session, including its power-down, has ended.

During low-power sleep the primary line follows the raw switch of the selected slot directly. When sleep ends, the primary line is held low for a wake-up delay plus one debounce window, so the host cannot start a session before the analogue parts have settled. Both times are parameters counted in clock cycles.

Top module: `card_slot_status`

## Requirements
- R1: A slot is reported present only after its detect input has been sampled high on DEB_CYC consecutive rising clock edges. With DEB_CYC=8, the primary line is still low after 7 such edges and high after the 8th.
- R2: A low sample on the detect input during the qualification window restarts the count from zero, so another DEB_CYC consecutive high samples are needed.
- R3: One low sample on the detect input of a present slot clears its presence at that clock edge. There is no debounce on removal.
- R4: `pull_a_o`/`pull_b_o` is high for exactly one cycle after the edge at which a present slot sees its detect input low while that slot's session input is high. With the session input low it stays low.
- R5: With `sel_b_i`=0 the primary line `sel_stat_n_o` describes slot A and the secondary line `oth_stat_n_o` describes slot B. With `sel_b_i`=1 the roles swap. The change takes effect without a clock edge.
- R6: The secondary line carries only debounced presence: a session fault on the nonselected slot leaves it high.
- R7: A fault input that is high at a clock edge while that slot's session input is high latches a fault. The latched fault drives the primary line low when that slot is selected, even after the fault input falls. The latch clears at the first edge at which the session input is low.
- R8: While `sleep_i` is high, the primary line equals the raw detect input of the selected slot, with no clock delay and no debounce.
- R9: After `sleep_i` falls, the primary line stays low. It is released at the first edge that lies WAKE_CYC+DEB_CYC edges after the first edge sampling `sleep_i` low.
- R10: After reset, both status lines are low and both removal requests are low until a card has been qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_a_i | input | 1 | Slot A card-detect switch, high = card, synchronous to clk |
| det_b_i | input | 1 | Slot B card-detect switch, high = card, synchronous to clk |
| sel_b_i | input | 1 | Slot select, 0 = slot A primary, 1 = slot B primary |
| sess_a_i | input | 1 | Sequencer: slot A session open or powering down |
| sess_b_i | input | 1 | Sequencer: slot B session open or powering down |
| fault_a_i | input | 1 | Fault detector event for slot A |
| fault_b_i | input | 1 | Fault detector event for slot B |
| sleep_i | input | 1 | Low-power sleep state |
| sel_stat_n_o | output | 1 | Primary status, low = selected slot empty, faulted or held |
| oth_stat_n_o | output | 1 | Secondary status, low = nonselected slot empty |
| pull_a_o | output | 1 | One-cycle removal request for slot A |
| pull_b_o | output | 1 | One-cycle removal request for slot B |

## Verification
Insertion is tried as a clean step and as a step with a bounce inside the window. Comparing the two separates a counter that restarts from one that only pauses or keeps counting. Removal is applied with the session input high and low, which shows that the request depends on the session and not only on the edge. Faults are injected on the selected and on the nonselected slot, which shows whether faults are routed to the primary line only. A sleep episode that drops and restores the card checks the raw pass-through, and counting the wake hold to the exact edge distinguishes WAKE_CYC+DEB_CYC from either term alone.

// File: rtl/card_slot_status_pkg.sv
package card_slot_status_pkg;

  typedef struct packed {
    logic pres;   // debounced presence
    logic ok;     // present and no latched fault
  } slot_view_t;

  // Total wake hold, in clock edges.
  function automatic int hold_total(input int wake_cyc, input int deb_cyc);
    return wake_cyc + deb_cyc;
  endfunction

  // Width of a down/up counter that must hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/slot_presence.sv
module slot_presence
  import card_slot_status_pkg::*;
#(
  parameter int DEB_CYC = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_i,
  input  logic       sess_i,
  input  logic       fault_i,
  output slot_view_t view_o,
  output logic       pull_o
);
  localparam int CW = cnt_width(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] qual_q;
  logic          pres_q;
  logic          flt_q;
  logic          pull_q;

  // Insertion qualified over a window, removal taken on first low sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= '0;
      pres_q <= 1'b0;
    end else if (!det_i) begin
      qual_q <= '0;
      pres_q <= 1'b0;
    end else if (!pres_q) begin
      if (qual_q == LAST) begin
        pres_q <= 1'b1;
        qual_q <= '0;
      end else begin
        qual_q <= qual_q + 1'b1;
      end
    end
  end

  // Fault latch lives for the duration of one session.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flt_q <= 1'b0;
    else if (!sess_i)  flt_q <= 1'b0;
    else if (fault_i)  flt_q <= 1'b1;
  end

  // Removal request: one cycle, only inside a session.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pres_q & ~det_i & sess_i;
  end

  assign view_o.pres = pres_q;
  assign view_o.ok   = pres_q & ~flt_q;
  assign pull_o      = pull_q;
endmodule

// File: rtl/wake_holdoff.sv
module wake_holdoff
  import card_slot_status_pkg::*;
#(
  parameter int WAKE_CYC = 11000,
  parameter int DEB_CYC  = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic hold_o
);
  localparam int HOLD = hold_total(WAKE_CYC, DEB_CYC);
  localparam int HW   = cnt_width(HOLD);

  logic          sleep_q;
  logic [HW-1:0] left_q;
  logic          wake_edge;

  assign wake_edge = sleep_q & ~sleep_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      left_q  <= '0;
    end else begin
      sleep_q <= sleep_i;
      if (sleep_i)             left_q <= '0;
      else if (wake_edge)      left_q <= HW'(HOLD);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end
  end

  assign hold_o = wake_edge | (left_q != '0);
endmodule

// File: rtl/card_slot_status.sv
module card_slot_status
  import card_slot_status_pkg::*;
#(
  parameter int DEB_CYC  = 400000,
  parameter int WAKE_CYC = 11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_a_i,
  input  logic det_b_i,
  input  logic sel_b_i,
  input  logic sess_a_i,
  input  logic sess_b_i,
  input  logic fault_a_i,
  input  logic fault_b_i,
  input  logic sleep_i,
  output logic sel_stat_n_o,
  output logic oth_stat_n_o,
  output logic pull_a_o,
  output logic pull_b_o
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0] det_v, sess_v, fault_v, pull_v;
  slot_view_t       view_v [NSLOT];
  logic             hold_w;
  slot_view_t       sel_view_w, oth_view_w;
  logic             sel_raw_w;

  assign det_v   = {det_b_i, det_a_i};
  assign sess_v  = {sess_b_i, sess_a_i};
  assign fault_v = {fault_b_i, fault_a_i};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    slot_presence #(.DEB_CYC(DEB_CYC)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .det_i  (det_v[s]),
      .sess_i (sess_v[s]),
      .fault_i(fault_v[s]),
      .view_o (view_v[s]),
      .pull_o (pull_v[s])
    );
  end

  wake_holdoff #(.WAKE_CYC(WAKE_CYC), .DEB_CYC(DEB_CYC)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .sleep_i(sleep_i),
    .hold_o (hold_w)
  );

  assign sel_view_w = sel_b_i ? view_v[1] : view_v[0];
  assign oth_view_w = sel_b_i ? view_v[0] : view_v[1];
  assign sel_raw_w  = sel_b_i ? det_b_i   : det_a_i;

  always_comb begin
    if (sleep_i)     sel_stat_n_o = sel_raw_w;
    else if (hold_w) sel_stat_n_o = 1'b0;
    else             sel_stat_n_o = sel_view_w.ok;
  end

  assign oth_stat_n_o = oth_view_w.pres;
  assign pull_a_o     = pull_v[0];
  assign pull_b_o     = pull_v[1];
endmodule

// File: rtl/card_slot_status_chk.sv
module card_slot_status_chk (
  input logic clk,
  input logic rst_n,
  input logic det_a_i,
  input logic sess_a_i,
  input logic fault_a_i,
  input logic sleep_i,
  input logic pull_a_o,
  input logic pres_a,
  input logic ok_a,
  input logic hold_w
);
  // R1
  qual_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres_a) |-> $past(det_a_i));

  // R3
  removal_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_a_i |=> !pres_a);

  // R4
  pull_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_a_o |-> ($past(sess_a_i) && !$past(det_a_i)));

  // R4
  pull_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_a_o |=> !pull_a_o);

  // R7
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_a_i && fault_a_i) |=> !ok_a);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_i) |=> hold_w);
endmodule

bind card_slot_status card_slot_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .det_a_i  (det_a_i),
  .sess_a_i (sess_a_i),
  .fault_a_i(fault_a_i),
  .sleep_i  (sleep_i),
  .pull_a_o (pull_a_o),
  .pres_a   (view_v[0].pres),
  .ok_a     (view_v[0].ok),
  .hold_w   (hold_w)
);

// File: tb/card_slot_status_tb_top.sv
`timescale 1ns/1ps
module card_slot_status_tb_top;
  localparam int DEB  = 8;
  localparam int WAKE = 5;
  localparam int HOLD = DEB + WAKE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_a = 0, det_b = 0, sel_b = 0, sess_a = 0, sess_b = 0;
  logic fault_a = 0, fault_b = 0, sleep = 0;
  logic sel_n, oth_n, pull_a, pull_b;

  always #10 clk = ~clk;

  card_slot_status #(.DEB_CYC(DEB), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .det_a_i(det_a), .det_b_i(det_b), .sel_b_i(sel_b),
    .sess_a_i(sess_a), .sess_b_i(sess_b),
    .fault_a_i(fault_a), .fault_b_i(fault_b), .sleep_i(sleep),
    .sel_stat_n_o(sel_n), .oth_stat_n_o(oth_n),
    .pull_a_o(pull_a), .pull_b_o(pull_b)
  );

  typedef struct {
    string req;
    logic  e_sel, e_oth, e_pa, e_pb;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Monitor: compares outputs away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ({sel_n, oth_n, pull_a, pull_b} !== {e.e_sel, e.e_oth, e.e_pa, e.e_pb}) begin
        errors++;
        $display("FAIL %s: got sel=%b oth=%b pa=%b pb=%b exp sel=%b oth=%b pa=%b pb=%b",
                 e.req, sel_n, oth_n, pull_a, pull_b, e.e_sel, e.e_oth, e.e_pa, e.e_pb);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic s, input logic o,
                            input logic pa, input logic pb);
    exp_t e;
    e.req = req; e.e_sel = s; e.e_oth = o; e.e_pa = pa; e.e_pb = pb;
    sb_q.push_back(e);
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_out("R10 reset", 0, 0, 0, 0);

    // R1: clean insertion on A
    det_a = 1;
    tick(DEB - 1);
    expect_out("R1 before window", 0, 0, 0, 0);
    tick(1);
    expect_out("R1 after window", 1, 0, 0, 0);

    // R3: removal
    det_a = 0;
    tick(1);
    expect_out("R3 removal", 0, 0, 0, 0);

    // R2: bounce restarts count
    det_a = 1; tick(5);
    det_a = 0; tick(1);
    det_a = 1; tick(DEB - 1);
    expect_out("R2 restarted window", 0, 0, 0, 0);
    tick(1);
    expect_out("R2 qualified", 1, 0, 0, 0);

    // R5/R6: B inserted shows on secondary, then swap
    det_b = 1; tick(DEB);
    expect_out("R6 other presence", 1, 1, 0, 0);
    det_a = 0; tick(1);
    expect_out("R5 sel A empty", 0, 1, 0, 0);
    sel_b = 1; #1;
    expect_out("R5 swapped", 1, 0, 0, 0);
    sel_b = 0;
    det_a = 1; tick(DEB);
    expect_out("R5 back to A", 1, 1, 0, 0);

    // R4: removal outside session gives no request
    det_b = 0; tick(1);
    expect_out("R4 no session", 1, 0, 0, 0);
    tick(1);
    expect_out("R4 no session later", 1, 0, 0, 0);
    det_b = 1; tick(DEB);

    // R4: removal inside session
    sess_b = 1; tick(1);
    det_b = 0; tick(1);
    expect_out("R4 request", 1, 0, 0, 1);
    tick(1);
    expect_out("R4 single cycle", 1, 0, 0, 0);
    sess_b = 0; det_b = 1; tick(DEB);

    // R6: fault on nonselected slot in session
    sess_b = 1; fault_b = 1; tick(1);
    fault_b = 0; tick(1);
    expect_out("R6 fault not on secondary", 1, 1, 0, 0);

    // R7: fault latch on selected A
    sess_a = 1; tick(1);
    fault_a = 1; tick(1);
    fault_a = 0;
    expect_out("R7 fault low", 0, 1, 0, 0);
    tick(3);
    expect_out("R7 latched", 0, 1, 0, 0);
    sel_b = 1; #1;
    expect_out("R7 B faulted too", 0, 1, 0, 0);
    sel_b = 0;
    sess_a = 0; sess_b = 0; tick(1);
    expect_out("R7 cleared", 1, 1, 0, 0);

    // R8: sleep follows raw presence
    sleep = 1; tick(2);
    det_a = 0; #1;
    expect_out("R8 raw low", 0, 1, 0, 0);
    det_a = 1; #1;
    expect_out("R8 raw high no debounce", 1, 1, 0, 0);
    tick(2);

    // R9: wake hold
    sleep = 0; #1;
    expect_out("R9 held at once", 0, 1, 0, 0);
    tick(1);
    expect_out("R9 first edge", 0, 1, 0, 0);
    tick(HOLD - 1);
    expect_out("R9 last held", 0, 1, 0, 0);
    tick(1);
    expect_out("R9 released", 1, 1, 0, 0);

    tick(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule